// File: doc/BRIEF.md
# Flash Access-Protection Controller

This block holds a small set of emulated one-time-programmable protection cells for an on-chip flash array. It decides whether flash access protection is currently in force, and it filters every flash data access according to where the request comes from. A cell starts erased at 1. Programming moves it to 0 and it never returns to 1. There is one access-protect cell and one debug-protect cell. There are also two chains of cells, disable and enable, and each chain has `CHAIN_LEN` entries.

Protection can be switched off and back on permanently, one step at a time, by working along the chains. Disable cell 0 is programmed first, then enable cell 0, then disable cell 1, and so on. The last cell programmed along the chain decides the state. If it is a disable cell, protection is lifted. If it is an enable cell, or no chain cell has been programmed yet, the access-protect cell alone decides. A program request that breaks the order is refused.

While protection is in force, only accesses made while executing from the flash itself are allowed. Other reads get dummy data, which is all ones, and a trap request. Other writes are dropped. Accesses from the peripheral transfer engine are refused.

Top module: `fapGuard`

## Requirements
- R1: After reset all cells read as erased, `protActive` is 0, and `progAccept`, `progReject` and `trapReq` are 0.
- R2: `progTarget` selects the cell group: 0 is access-protect, 1 is debug-protect, 2 is the disable chain and 3 is the enable chain. `progIndex` selects the chain entry. An allowed strobe programs the cell at that clock edge, and `progAccept` is high for exactly the following cycle.
- R3: A strobe that targets a cell which is already programmed gives a one-cycle `progReject` in the following cycle, and no cell changes.
- R4: Disable cell 0 can be programmed only once both the access-protect cell and the debug-protect cell are programmed. Otherwise the strobe is rejected.
- R5: Disable cell x with x > 0 needs enable cell x-1 to be programmed first. Enable cell x needs disable cell x to be programmed first. A strobe that breaks either rule is rejected.
- R6: `protActive` is 1 when the access-protect cell is programmed and the highest chain index that has a programmed cell does not end on a disable cell, meaning its enable cell is also programmed.
- R7: While protected, a read that is not fetched from flash and not from the peripheral engine is denied. It gives `dummySel`=1 in the same cycle, and in the next cycle `trapReq` is high for one cycle with `trapVector`=16'h009B. At all other times `trapVector` is 0.
- R8: While protected, a write whose execution origin is not flash is denied and gives no dummy select and no trap.
- R9: While protected, any access flagged `fromPeriph` is denied, and a read of this kind gives `dummySel` but no trap. Accesses that are fetched from flash and not from the peripheral engine are granted.
- R10: While not protected, every valid access is granted, with no dummy select and no trap.
- R11: Once enable cell `CHAIN_LEN-1` is programmed, every disable cell has been used, so every further disable strobe is rejected and protection stays on for good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progStrobe | input | 1 | Program request, one cycle |
| progTarget | input | 2 | Cell group selector (see R2) |
| progIndex | input | 4 | Chain entry index |
| accValid | input | 1 | Flash data access present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| fetchFromFlash | input | 1 | Current execution is from flash |
| fromPeriph | input | 1 | Access made by the peripheral transfer engine |
| progAccept | output | 1 | Program request taken (one-cycle pulse) |
| progReject | output | 1 | Program request refused (one-cycle pulse) |
| accGrant | output | 1 | Access allowed to reach flash |
| dummySel | output | 1 | Return all-ones dummy read data |
| trapReq | output | 1 | Software trap request pulse |
| trapVector | output | 16 | Trap vector, valid with `trapReq` |
| protActive | output | 1 | Access protection in force |

## Verification
Each protection state is probed with the full set of eight access patterns, formed from read or write, flash or non-flash origin, and peripheral or not. Comparing them shows which origin is filtered, which denial gives dummy data, and which one raises the trap. The chain is walked through all entries, with a probe after every step, so the parity rule is seen flipping at every index. Out-of-order strobes and repeated strobes are sent at the start of the chain, in the middle and past its end. They show that the ordering checks and the one-way rule reject the request and leave both the state and the access filtering unchanged.

// File: rtl/fapPkg.sv
package fapPkg;
  parameter int CHAIN_LEN = 16;
  localparam int IDX_W = $clog2(CHAIN_LEN);
  localparam logic [15:0] TRAP_VEC = 16'h009B;

  typedef enum logic [1:0] {
    TGT_ACC = 2'd0,
    TGT_DBG = 2'd1,
    TGT_DIS = 2'd2,
    TGT_EN  = 2'd3
  } progTgtE;

  typedef struct packed {
    logic             setAcc;
    logic             setDbg;
    logic             setDis;
    logic             setEn;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic             reject;
  } progStrobeS;
endpackage

// File: rtl/fapCtrl.sv
module fapCtrl
  import fapPkg::*;
(
  input  logic                 progStrobe,
  input  logic [1:0]           progTarget,
  input  logic [IDX_W-1:0]     progIndex,
  input  logic                 accBit,
  input  logic                 dbgBit,
  input  logic [CHAIN_LEN-1:0] disBits,
  input  logic [CHAIN_LEN-1:0] enBits,
  output progStrobeS           strobes
);
  logic allowed;
  logic prevEnDone;

  // Enable cell of the previous chain entry, or the cells that guard entry 0 (R4, R5)
  always_comb begin
    if (progIndex == '0) prevEnDone = !accBit && !dbgBit;
    else                 prevEnDone = !enBits[progIndex - 1'b1];
  end

  always_comb begin
    strobes = '0;
    strobes.idx = progIndex;
    allowed = 1'b0;
    case (progTgtE'(progTarget))
      TGT_ACC: allowed = accBit;
      TGT_DBG: allowed = dbgBit;
      TGT_DIS: allowed = disBits[progIndex] && prevEnDone;
      TGT_EN:  allowed = enBits[progIndex] && !disBits[progIndex];
      default: allowed = 1'b0;
    endcase
    if (progStrobe) begin
      strobes.accept = allowed;
      strobes.reject = !allowed;
      strobes.setAcc = allowed && (progTgtE'(progTarget) == TGT_ACC);
      strobes.setDbg = allowed && (progTgtE'(progTarget) == TGT_DBG);
      strobes.setDis = allowed && (progTgtE'(progTarget) == TGT_DIS);
      strobes.setEn  = allowed && (progTgtE'(progTarget) == TGT_EN);
    end
  end
endmodule

// File: rtl/fapData.sv
module fapData
  import fapPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  progStrobeS           strobes,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic                 fetchFromFlash,
  input  logic                 fromPeriph,
  output logic                 accBit,
  output logic                 dbgBit,
  output logic [CHAIN_LEN-1:0] disBits,
  output logic [CHAIN_LEN-1:0] enBits,
  output logic                 progAccept,
  output logic                 progReject,
  output logic                 accGrant,
  output logic                 dummySel,
  output logic                 trapReq,
  output logic [15:0]          trapVector,
  output logic                 protActive
);
  localparam int LAST = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] offAt;
  logic                 protOff;
  logic                 trapNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accBit     <= 1'b1;
      dbgBit     <= 1'b1;
      disBits    <= '1;
      enBits     <= '1;
      progAccept <= 1'b0;
      progReject <= 1'b0;
      trapReq    <= 1'b0;
    end else begin
      if (strobes.setAcc) accBit <= 1'b0;
      if (strobes.setDbg) dbgBit <= 1'b0;
      if (strobes.setDis) disBits[strobes.idx] <= 1'b0;
      if (strobes.setEn)  enBits[strobes.idx]  <= 1'b0;
      progAccept <= strobes.accept;
      progReject <= strobes.reject;
      trapReq    <= trapNext;
    end
  end

  // Entry k ends the chain on a disable cell: its disable is used, its enable is not,
  // and the next entry's disable is still erased
  for (genvar k = 0; k < CHAIN_LEN; k++) begin : gChain
    if (k == LAST) begin : gTail
      assign offAt[k] = !disBits[k] && enBits[k];
    end else begin : gBody
      assign offAt[k] = !disBits[k] && enBits[k] && disBits[k+1];
    end
  end

  assign protOff    = |offAt;
  assign protActive = !accBit && !protOff;

  always_comb begin
    accGrant = 1'b0;
    dummySel = 1'b0;
    if (accValid) begin
      if (!protActive) begin
        accGrant = 1'b1;
      end else if (fromPeriph || !fetchFromFlash) begin
        dummySel = !accWrite;
      end else begin
        accGrant = 1'b1;
      end
    end
  end

  assign trapNext   = accValid && !accWrite && protActive && !fromPeriph && !fetchFromFlash;
  assign trapVector = trapReq ? TRAP_VEC : 16'h0000;

  // R3: cells only move from erased to programmed
  a_r3_one_way: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((disBits & ~$past(disBits)) == '0) && ((enBits & ~$past(enBits)) == '0)));
  // R3: a rejected request left every cell as it was
  a_r3_reject_stable: assert property (@(posedge clk) disable iff (!rstN)
    progReject |-> ($stable(disBits) && $stable(enBits) && $stable(accBit) && $stable(dbgBit)));
  a_r2_pulse_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progAccept, progReject}));
  // R7: a trap follows a denied read
  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(accValid && !accWrite && !accGrant && !fromPeriph));
  // R9: peripheral engine never reaches protected flash
  a_r9_periph_block: assert property (@(posedge clk) disable iff (!rstN)
    (protActive && accValid && fromPeriph) |-> !accGrant);
  // R10: without protection nothing is filtered
  a_r10_open: assert property (@(posedge clk) disable iff (!rstN)
    (!protActive && accValid) |-> (accGrant && !dummySel));
  // R6: a programmed chain never holds more than one open-ended disable
  a_r6_single_tail: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(offAt));
endmodule

// File: rtl/fapGuard.sv
module fapGuard
  import fapPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             progStrobe,
  input  logic [1:0]       progTarget,
  input  logic [IDX_W-1:0] progIndex,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             fetchFromFlash,
  input  logic             fromPeriph,
  output logic             progAccept,
  output logic             progReject,
  output logic             accGrant,
  output logic             dummySel,
  output logic             trapReq,
  output logic [15:0]      trapVector,
  output logic             protActive
);
  progStrobeS           strobes;
  logic                 accBit;
  logic                 dbgBit;
  logic [CHAIN_LEN-1:0] disBits;
  logic [CHAIN_LEN-1:0] enBits;

  fapCtrl uCtrl (
    .progStrobe (progStrobe),
    .progTarget (progTarget),
    .progIndex  (progIndex),
    .accBit     (accBit),
    .dbgBit     (dbgBit),
    .disBits    (disBits),
    .enBits     (enBits),
    .strobes    (strobes)
  );

  fapData uData (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .accValid       (accValid),
    .accWrite       (accWrite),
    .fetchFromFlash (fetchFromFlash),
    .fromPeriph     (fromPeriph),
    .accBit         (accBit),
    .dbgBit         (dbgBit),
    .disBits        (disBits),
    .enBits         (enBits),
    .progAccept     (progAccept),
    .progReject     (progReject),
    .accGrant       (accGrant),
    .dummySel       (dummySel),
    .trapReq        (trapReq),
    .trapVector     (trapVector),
    .protActive     (protActive)
  );
endmodule

// File: tb/sim_fapGuard.sv
module sim_fapGuard;
  localparam time CLK_PERIOD = 10;
  localparam int  N = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progStrobe = 1'b0;
  logic [1:0] progTarget = '0;
  logic [3:0] progIndex = '0;
  logic       accValid = 1'b0, accWrite = 1'b0, fetchFromFlash = 1'b0, fromPeriph = 1'b0;
  logic       progAccept, progReject, accGrant, dummySel, trapReq, protActive;
  logic [15:0] trapVector;

  int compared = 0;
  int mismatched = 0;

  // Behavioural reference state
  bit mAcc, mDbg;
  bit mDisUsed[N];
  bit mEnUsed[N];
  bit mAccept, mReject, mTrap;

  always #(CLK_PERIOD/2) clk = ~clk;

  fapGuard u0 (
    .clk(clk), .rstN(rstN), .progStrobe(progStrobe), .progTarget(progTarget),
    .progIndex(progIndex), .accValid(accValid), .accWrite(accWrite),
    .fetchFromFlash(fetchFromFlash), .fromPeriph(fromPeriph),
    .progAccept(progAccept), .progReject(progReject), .accGrant(accGrant),
    .dummySel(dummySel), .trapReq(trapReq), .trapVector(trapVector),
    .protActive(protActive)
  );

  function automatic bit modelProt();
    for (int k = N - 1; k >= 0; k--) begin
      if (mEnUsed[k]) return mAcc;
      if (mDisUsed[k]) return 1'b0;
    end
    return mAcc;
  endfunction

  function automatic bit modelLegal(input logic [1:0] tgt, input int idx);
    case (tgt)
      2'd0: return !mAcc;
      2'd1: return !mDbg;
      2'd2: begin
        if (mDisUsed[idx]) return 1'b0;
        if (idx == 0) return mAcc && mDbg;
        return mEnUsed[idx-1];
      end
      default: return !mEnUsed[idx] && mDisUsed[idx];
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mDbg = 0; mAccept = 0; mReject = 0; mTrap = 0;
      for (int k = 0; k < N; k++) begin mDisUsed[k] = 0; mEnUsed[k] = 0; end
    end else begin
      bit ok;
      mTrap = accValid && !accWrite && modelProt() && !fromPeriph && !fetchFromFlash;
      ok = progStrobe && modelLegal(progTarget, int'(progIndex));
      mAccept = ok;
      mReject = progStrobe && !ok;
      if (ok) begin
        case (progTarget)
          2'd0: mAcc = 1;
          2'd1: mDbg = 1;
          2'd2: mDisUsed[progIndex] = 1;
          default: mEnUsed[progIndex] = 1;
        endcase
      end
    end
  end

  task automatic cmp(input string tag, input string name, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, then compare every output against the model
  task automatic step(input string tag, input bit ps, input logic [1:0] tgt, input int idx,
                      input bit av, input bit wr, input bit ff, input bit pe);
    bit p, g, d;
    @(negedge clk);
    progStrobe = ps; progTarget = tgt; progIndex = 4'(idx);
    accValid = av; accWrite = wr; fetchFromFlash = ff; fromPeriph = pe;
    #1;
    p = modelProt();
    g = av && (!p || (ff && !pe));
    d = av && p && !wr && (pe || !ff);
    cmp(tag, "protActive", {15'b0, protActive}, {15'b0, p});
    cmp(tag, "accGrant", {15'b0, accGrant}, {15'b0, g});
    cmp(tag, "dummySel", {15'b0, dummySel}, {15'b0, d});
    cmp(tag, "progAccept", {15'b0, progAccept}, {15'b0, mAccept});
    cmp(tag, "progReject", {15'b0, progReject}, {15'b0, mReject});
    cmp(tag, "trapReq", {15'b0, trapReq}, {15'b0, mTrap});
    cmp(tag, "trapVector", trapVector, mTrap ? 16'h009B : 16'h0000);
  endtask

  task automatic prog(input string tag, input logic [1:0] tgt, input int idx);
    step(tag, 1, tgt, idx, 0, 0, 0, 0);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // All eight access patterns, each followed by an idle cycle that shows any trap
  task automatic sweep(input string tag);
    for (int c = 0; c < 8; c++) begin
      step(tag, 0, 0, 0, 1, c[0], c[1], c[2]);
      step(tag, 0, 0, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    sweep("R10");
    prog("R4", 2'd2, 0);            // disable 0 before protect cells: rejected
    prog("R2", 2'd1, 0);            // debug-protect
    prog("R4", 2'd2, 0);            // still rejected: access-protect not yet programmed
    prog("R2", 2'd0, 0);            // access-protect: protection on
    prog("R3", 2'd0, 0);            // repeat: rejected
    sweep("R7");
    sweep("R8");
    sweep("R9");
    prog("R5", 2'd3, 0);            // enable 0 before disable 0
    prog("R5", 2'd2, 1);            // disable 1 before enable 0
    sweep("R6");
    for (int x = 0; x < N; x++) begin
      prog("R6", 2'd2, x);          // protection off
      prog("R3", 2'd2, x);
      prog("R5", 2'd2, (x + 1) % N);
      sweep("R10");
      prog("R6", 2'd3, x);          // protection back on
      prog("R3", 2'd3, x);
      sweep("R7");
    end
    for (int x = 0; x < N; x++) prog("R11", 2'd2, x);
    sweep("R11");
    rstN = 1'b0;
    #1;
    @(negedge clk);
    rstN = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule